// File: doc/BRIEF.md
# Vector Element-Group Issue Sequencer

This block takes one vector operation that treats a fixed number of equal-width elements as a single unit (an element group), decides whether the operation may run at all, and then walks over the groups it covers one clock at a time. For every group it reports which vector register holds the group's first bit, the bit position inside that register, how many consecutive registers one group fills, and whether this is the final group of the operation. The group width in bits is the element width times the group size. When that width fits in one register, several groups share a register. When it is wider, one group spans a run of consecutive registers.

The group size comes from the opcode and the element width from the current selected-element-width code. Element count `vl` and start position `vstart` are both counted in elements. A bad pairing of width and size, a misaligned count or start, a base register not aligned to the span, or a group that would run past the last register ends the operation with a one-cycle illegal-instruction pulse and no groups issued. The register length in bits is a parameter.

The control is a four-state machine. ST_IDLE waits for `start_i`. From there it goes to ST_FAULT if the configuration is illegal, to ST_FIN if no group lies between `vstart` and `vl`, and to ST_ISSUE otherwise. ST_ISSUE issues one group per cycle and stays there until the final group, then goes to ST_FIN. ST_FIN and ST_FAULT each last one cycle and return to ST_IDLE.

Top module: `egrp_seq`

## Requirements
- R1: The width code `sew_i` selects elements of 8<<sew_i bits. Only three pairs are legal: (sew_i=2, egs_i=4), (sew_i=2, egs_i=8) and (sew_i=3, egs_i=4), giving 128, 256 and 256 bit groups. Any other pair, including codes 4 to 7 (elements wider than 64 bits), raises `illegal_o`.
- R2: A `vl_i` that is not a multiple of `egs_i` raises `illegal_o`.
- R3: A `vstart_i` that is not a multiple of `egs_i` raises `illegal_o`.
- R4: When the group width EGW is at most VLEN, group g is reported at register (base + g*EGW/VLEN) mod 32 and bit offset (g*EGW) mod VLEN, with `grp_span_o` = 1.
- R5: When EGW exceeds VLEN, `grp_span_o` = EGW/VLEN, group g starts in register base + g*span, and the offset is 0.
- R6: A base register that is not a multiple of the span raises `illegal_o`.
- R7: If groups would be issued and the last register touched by element vl-1 is above 31, `illegal_o` is raised. Reaching exactly register 31 is legal.
- R8: Groups vstart/EGS through vl/EGS-1 are issued in ascending order on consecutive cycles. The first is issued in the cycle after `start_i` is sampled. `grp_last_o` marks only the final group.
- R9: `done_o` pulses for one cycle right after the final group. When vstart >= vl, no group is issued and `done_o` pulses in the cycle after `start_i`.
- R10: For an illegal operation, `illegal_o` pulses for one cycle in the cycle after `start_i`. No group and no `done_o` appear for that operation.
- R11: `start_i` is ignored while an operation is in progress. The running sequence is unchanged, and no fault results from the ignored request.
- R12: After reset, `grp_valid_o`, `grp_last_o`, `done_o` and `illegal_o` are low, and the index, offset and span outputs are zero.

Vector state, register file, arithmetic, masking and tail handling are outside this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin an operation (sampled in idle only) |
| sew_i | input | 3 | Element width code, width = 8<<code |
| egs_i | input | 4 | Elements per group, from the opcode |
| vl_i | input | VL_W | Element count |
| vstart_i | input | VL_W | First element |
| base_i | input | 5 | First register of the operand |
| grp_valid_o | output | 1 | A group is being issued this cycle |
| grp_reg_o | output | 5 | Register holding the group's first bit |
| grp_off_o | output | log2(VLEN) | Bit offset of the group in that register |
| grp_span_o | output | 4 | Registers covered by one group |
| grp_last_o | output | 1 | Final group of the operation |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The checker assumes the configuration inputs are only meaningful in the cycle where `start_i` is sampled in idle. It also assumes that a legal operation never wraps the register index, since the overflow rule turns any such case into a fault. The ascending-order property depends on that second assumption.

The bench holds each configuration steady from one falling edge through the next rising edge. It always releases `start_i` after one cycle. Its only mid-run change to the inputs is the deliberate ignored request, which uses an illegal width code so that wrongly accepting it would be visible.

// File: rtl/egrp_pkg.sv
package egrp_pkg;
    localparam int REG_W  = 5;
    localparam int NREG   = 32;
    localparam int SEW_W  = 3;
    localparam int EGS_W  = 4;
    localparam int SPAN_W = 4;
    localparam int LOG_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FIN,
        ST_FAULT
    } egrp_state_e;
endpackage

// File: rtl/egrp_legal.sv
module egrp_legal
    import egrp_pkg::*;
#(
    parameter int VLEN_LOG = 8,
    parameter int VL_W     = 12
) (
    input  logic [SEW_W-1:0]  sew,
    input  logic [EGS_W-1:0]  egs,
    input  logic [VL_W-1:0]   vl,
    input  logic [VL_W-1:0]   vstart,
    input  logic [REG_W-1:0]  base,
    output logic              illegal,
    output logic              empty,
    output logic [LOG_W-1:0]  egw_log,
    output logic [SPAN_W-1:0] span,
    output logic [VL_W-1:0]   g_first,
    output logic [VL_W-1:0]   g_last
);
    localparam int HI_W = VL_W + 12;

    logic [LOG_W-1:0] egs_log;
    logic [LOG_W-1:0] span_log;
    logic [VL_W-1:0]  egs_mask;
    logic             pair_ok, vl_ok, vs_ok, base_ok, over;
    logic [HI_W-1:0]  last_bit, reg_hi;

    always_comb begin
        egs_log  = (egs == EGS_W'(8)) ? LOG_W'(3) : LOG_W'(2);
        pair_ok  = ((sew == SEW_W'(2)) && ((egs == EGS_W'(4)) || (egs == EGS_W'(8))))
                 || ((sew == SEW_W'(3)) && (egs == EGS_W'(4)));
        egw_log  = {1'b0, sew} + LOG_W'(3) + egs_log;
        egs_mask = VL_W'(egs) - VL_W'(1);
        vl_ok    = (vl & egs_mask) == '0;
        vs_ok    = (vstart & egs_mask) == '0;
        span_log = (egw_log > LOG_W'(VLEN_LOG)) ? (egw_log - LOG_W'(VLEN_LOG)) : '0;
        span     = SPAN_W'(1) << span_log;
        base_ok  = (base & (REG_W'(span) - REG_W'(1))) == '0;
        empty    = vstart >= vl;
        last_bit = (HI_W'(vl) << ({1'b0, sew} + LOG_W'(3))) - HI_W'(1);
        reg_hi   = HI_W'(base) + (last_bit >> VLEN_LOG);
        over     = !empty && (reg_hi > HI_W'(NREG - 1));
        illegal  = !pair_ok || !vl_ok || !vs_ok || !base_ok || over;
        g_first  = vstart >> egs_log;
        g_last   = (vl >> egs_log) - VL_W'(1);
    end
endmodule

// File: rtl/egrp_addr.sv
module egrp_addr
    import egrp_pkg::*;
#(
    parameter int VLEN_LOG = 8,
    parameter int VL_W     = 12
) (
    input  logic [VL_W-1:0]     grp,
    input  logic [LOG_W-1:0]    egw_log,
    input  logic [REG_W-1:0]    base,
    output logic [REG_W-1:0]    reg_idx,
    output logic [VLEN_LOG-1:0] off
);
    localparam int P_W = VL_W + 16;

    logic [P_W-1:0] bitpos;
    logic [P_W-1:0] reg_step;

    always_comb begin
        bitpos   = P_W'(grp) << egw_log;
        reg_step = bitpos >> VLEN_LOG;
        reg_idx  = base + reg_step[REG_W-1:0];
        off      = bitpos[VLEN_LOG-1:0];
    end
endmodule

// File: rtl/egrp_seq.sv
module egrp_seq
    import egrp_pkg::*;
#(
    parameter int VLEN  = 256,
    parameter int VL_W  = 12,
    parameter int OFF_W = $clog2(VLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEW_W-1:0]  sew_i,
    input  logic [EGS_W-1:0]  egs_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [VL_W-1:0]   vstart_i,
    input  logic [REG_W-1:0]  base_i,
    output logic              grp_valid_o,
    output logic [REG_W-1:0]  grp_reg_o,
    output logic [OFF_W-1:0]  grp_off_o,
    output logic [SPAN_W-1:0] grp_span_o,
    output logic              grp_last_o,
    output logic              done_o,
    output logic              illegal_o
);
    egrp_state_e       state_q, state_d;
    logic [VL_W-1:0]   g_q, g_end_q;
    logic [LOG_W-1:0]  egw_log_q;
    logic [REG_W-1:0]  base_q;
    logic [SPAN_W-1:0] span_q;

    logic              c_illegal, c_empty;
    logic [LOG_W-1:0]  c_egw_log;
    logic [SPAN_W-1:0] c_span;
    logic [VL_W-1:0]   c_first, c_last;
    logic [REG_W-1:0]  a_reg;
    logic [OFF_W-1:0]  a_off;
    logic              at_end;

    egrp_legal #(.VLEN_LOG(OFF_W), .VL_W(VL_W)) u_legal (
        .sew     (sew_i),
        .egs     (egs_i),
        .vl      (vl_i),
        .vstart  (vstart_i),
        .base    (base_i),
        .illegal (c_illegal),
        .empty   (c_empty),
        .egw_log (c_egw_log),
        .span    (c_span),
        .g_first (c_first),
        .g_last  (c_last)
    );

    egrp_addr #(.VLEN_LOG(OFF_W), .VL_W(VL_W)) u_addr (
        .grp     (g_q),
        .egw_log (egw_log_q),
        .base    (base_q),
        .reg_idx (a_reg),
        .off     (a_off)
    );

    assign at_end = (g_q == g_end_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (c_illegal)    state_d = ST_FAULT;
                    else if (c_empty) state_d = ST_FIN;
                    else              state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: if (at_end) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            g_q       <= '0;
            g_end_q   <= '0;
            egw_log_q <= '0;
            base_q    <= '0;
            span_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                g_q       <= c_first;
                g_end_q   <= c_last;
                egw_log_q <= c_egw_log;
                base_q    <= base_i;
                span_q    <= c_span;
            end else if (state_q == ST_ISSUE && !at_end) begin
                g_q <= g_q + VL_W'(1);
            end
        end
    end

    always_comb begin
        grp_valid_o = (state_q == ST_ISSUE);
        grp_last_o  = grp_valid_o && at_end;
        grp_reg_o   = grp_valid_o ? a_reg  : '0;
        grp_off_o   = grp_valid_o ? a_off  : '0;
        grp_span_o  = grp_valid_o ? span_q : '0;
        done_o      = (state_q == ST_FIN);
        illegal_o   = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/egrp_seq_chk.sv
module egrp_seq_chk
    import egrp_pkg::*;
#(
    parameter int VLEN  = 256,
    parameter int OFF_W = $clog2(VLEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grp_valid_o,
    input logic [REG_W-1:0]  grp_reg_o,
    input logic [OFF_W-1:0]  grp_off_o,
    input logic [SPAN_W-1:0] grp_span_o,
    input logic              grp_last_o,
    input logic              done_o,
    input logic              illegal_o
);
    // R10
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grp_valid_o, done_o, illegal_o}));

    // R10
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> !grp_valid_o && !illegal_o);

    // R8
    issue_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid_o && !grp_last_o |=> grp_valid_o);

    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid_o && grp_last_o |=> done_o && !grp_valid_o);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    span_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid_o && (grp_span_o > SPAN_W'(1)) |-> grp_off_o == '0);

    // R8
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid_o && $past(grp_valid_o) && !$past(grp_last_o)
            |-> {grp_reg_o, grp_off_o} > $past({grp_reg_o, grp_off_o}));

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid_o |-> (grp_reg_o == '0) && (grp_off_o == '0) && (grp_span_o == '0) && !grp_last_o);
endmodule

bind egrp_seq egrp_seq_chk #(.VLEN(VLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grp_valid_o (grp_valid_o),
    .grp_reg_o   (grp_reg_o),
    .grp_off_o   (grp_off_o),
    .grp_span_o  (grp_span_o),
    .grp_last_o  (grp_last_o),
    .done_o      (done_o),
    .illegal_o   (illegal_o)
);

// File: tb/tb_egrp_seq.sv
module tb_egrp_seq;
    localparam int VL_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [2:0] sew_i = '0;
    logic [3:0] egs_i = '0;
    logic [VL_W-1:0] vl_i = '0, vstart_i = '0;
    logic [4:0] base_i = '0;

    logic l_v, l_last, l_done, l_ill, s_v, s_last, s_done, s_ill;
    logic [4:0] l_reg, s_reg;
    logic [7:0] l_off;
    logic [6:0] s_off;
    logic [3:0] l_span, s_span;

    int checks = 0;
    int fails  = 0;
    bit use_s  = 0;

    always #5ns clk = ~clk;

    egrp_seq #(.VLEN(256), .VL_W(VL_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i && !use_s), .sew_i(sew_i), .egs_i(egs_i),
        .vl_i(vl_i), .vstart_i(vstart_i), .base_i(base_i),
        .grp_valid_o(l_v), .grp_reg_o(l_reg), .grp_off_o(l_off), .grp_span_o(l_span),
        .grp_last_o(l_last), .done_o(l_done), .illegal_o(l_ill));

    egrp_seq #(.VLEN(128), .VL_W(VL_W)) dut_s (
        .clk(clk), .rst_n(rst_n), .start_i(start_i && use_s), .sew_i(sew_i), .egs_i(egs_i),
        .vl_i(vl_i), .vstart_i(vstart_i), .base_i(base_i),
        .grp_valid_o(s_v), .grp_reg_o(s_reg), .grp_off_o(s_off), .grp_span_o(s_span),
        .grp_last_o(s_last), .done_o(s_done), .illegal_o(s_ill));

    logic o_v, o_last, o_done, o_ill;
    int   o_reg, o_off, o_span;
    always_comb begin
        o_v    = use_s ? s_v    : l_v;
        o_last = use_s ? s_last : l_last;
        o_done = use_s ? s_done : l_done;
        o_ill  = use_s ? s_ill  : l_ill;
        o_reg  = use_s ? int'(s_reg)  : int'(l_reg);
        o_off  = use_s ? int'(s_off)  : int'(l_off);
        o_span = use_s ? int'(s_span) : int'(l_span);
    end

    task automatic chk(input string tag, input bit ok, input string got, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", tag, got, exp);
        end
    endtask

    // Runs one operation and checks every cycle of its outcome.
    task automatic op(input string tag, input bit sm, input int sew, input int egs,
                      input int vl, input int vst, input int base, input bit exp_ill,
                      input bit poke);
        int vlen  = sm ? 128 : 256;
        int egw   = (8 << sew) * egs;
        int span  = (egw > vlen) ? egw / vlen : 1;
        int first = vst / egs;
        int last  = vl / egs - 1;
        use_s = sm;
        @(negedge clk);
        sew_i = 3'(sew); egs_i = 4'(egs); vl_i = VL_W'(vl); vstart_i = VL_W'(vst);
        base_i = 5'(base); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (exp_ill) begin
            chk(tag, o_ill && !o_v && !o_done,
                $sformatf("ill=%0b v=%0b d=%0b", o_ill, o_v, o_done), "ill=1 v=0 d=0");
            @(negedge clk);
            chk(tag, !o_ill && !o_v && !o_done,
                $sformatf("ill=%0b v=%0b d=%0b", o_ill, o_v, o_done), "all low");
            return;
        end
        for (int g = first; g <= last; g++) begin
            int er = (base + (g * egw) / vlen) % 32;
            int eo = (g * egw) % vlen;
            chk(tag, o_v && !o_ill && o_reg == er && o_off == eo && o_span == span
                     && o_last == (g == last),
                $sformatf("v=%0b ill=%0b reg=%0d off=%0d span=%0d last=%0b",
                          o_v, o_ill, o_reg, o_off, o_span, o_last),
                $sformatf("v=1 ill=0 reg=%0d off=%0d span=%0d last=%0b",
                          er, eo, span, g == last));
            if (poke && g == first) begin
                start_i = 1'b1; sew_i = 3'd7;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(tag, o_done && !o_v && !o_ill,
            $sformatf("d=%0b v=%0b ill=%0b", o_done, o_v, o_ill), "d=1 v=0 ill=0");
        @(negedge clk);
        chk(tag, !o_done && !o_v && !o_ill,
            $sformatf("d=%0b v=%0b ill=%0b", o_done, o_v, o_ill), "all low");
    endtask

    task automatic t_reset();
        // R12
        chk("R12", !l_v && !l_done && !l_ill && !l_last && l_reg == 0 && l_off == 0 && l_span == 0,
            $sformatf("v=%0b d=%0b ill=%0b reg=%0d off=%0d", l_v, l_done, l_ill, l_reg, l_off),
            "all zero");
        chk("R12", !s_v && !s_done && !s_ill && s_span == 0,
            $sformatf("v=%0b d=%0b ill=%0b", s_v, s_done, s_ill), "all zero");
    endtask

    task automatic t_pack();     op("R4", 0, 2, 4, 16, 0, 4, 0, 0); endtask
    task automatic t_vstart();   op("R8", 0, 2, 4, 24, 8, 0, 0, 0); endtask
    task automatic t_wide_fit(); op("R4", 0, 3, 4, 12, 0, 3, 0, 0); endtask
    task automatic t_span();     op("R5", 1, 2, 8, 16, 0, 2, 0, 0); endtask
    task automatic t_span_bad(); op("R6", 1, 2, 8, 16, 0, 3, 1, 0); endtask
    task automatic t_pairs();
        op("R1", 0, 1, 4, 8, 0, 0, 1, 0);
        op("R1", 0, 2, 2, 8, 0, 0, 1, 0);
        op("R1", 0, 4, 4, 8, 0, 0, 1, 0);
        op("R1", 0, 3, 8, 8, 0, 0, 1, 0);
    endtask
    task automatic t_vl_bad();   op("R2", 0, 2, 4, 10, 0, 0, 1, 0); endtask
    task automatic t_vs_bad();   op("R3", 0, 2, 8, 16, 4, 0, 1, 0); endtask
    task automatic t_overflow();
        op("R7", 0, 3, 4, 12, 0, 30, 1, 0);
        op("R7", 0, 3, 4, 12, 0, 29, 0, 0);
    endtask
    task automatic t_empty();
        op("R9", 0, 2, 4, 8, 8, 0, 0, 0);
        op("R9", 0, 2, 4, 8, 16, 0, 0, 0);
    endtask
    task automatic t_busy();     op("R11", 0, 2, 4, 16, 0, 0, 0, 1); endtask

    initial begin
        #2_000_000ns;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pack();
        t_vstart();
        t_wide_fit();
        t_span();
        t_span_bad();
        t_pairs();
        t_vl_bad();
        t_vs_bad();
        t_overflow();
        t_empty();
        t_busy();
        op("R10", 0, 5, 4, 8, 0, 0, 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule